// File: doc/BRIEF.md
# One-Second Timebase Divider

This block turns a 32768 Hz reference, delivered as a one-cycle enable pulse on a faster system clock, into the slow timing signals a counting or timekeeping design needs. The whole chain is a single synchronous binary counter advanced by the enable, with no rippled clocks. A core of fourteen halving stages ends at 2 Hz. Ten frequencies from that core are brought out as tap outputs. Two further stages give a 1 Hz square wave and a 0.5 Hz gate. The gate is high for exactly one second and low for exactly one second, so it can serve as a counting window.

A one-cycle tick marks each rising edge of the 1 Hz output. Downstream seconds counters can use it directly as a clock enable. All outputs are plain level signals and carry no handshake. The number of core stages is a parameter (`CORE_STAGES`, at least 11). Lowering it shortens the time to reach one second in simulation. The taps stay in the same positions relative to the 2 Hz stage, so the ratios between them do not change.

Top module: `xtal_sec_timebase`

## Requirements
- R1: While `rst` is high at a clock edge, every stage is cleared after that edge: `taps` = 0, `sq_1hz` = 0, `gate_half_hz` = 0 and `tick_1hz` = 0.
- R2: An edge with `ref_en` low and `rst` low leaves every output unchanged, and `tick_1hz` is 0 after it.
- R3: Let n be the number of `ref_en` edges since reset, and let C be `CORE_STAGES`. Then `taps[j]` equals bit (C - d_j - 1) of n, with d = {10,9,8,7,6,5,4,2,1,0} for j = 0..9. With C = 14 these are 2048, 1024, 512, 256, 128, 64, 32, 8, 4 and 2 Hz. The 16 Hz stage and the first three stages are not exported.
- R4: `sq_1hz` equals bit C of n. It is low for the first 2^C enables after reset and then high for 2^C enables, which gives 1 Hz at a 50 % duty cycle.
- R5: `gate_half_hz` equals bit C+1 of n. It changes only in the cycle in which `sq_1hz` falls, and it stays high for 2^(C+1) enables, which is one full second.
- R6: `tick_1hz` is high for exactly one cycle: the first cycle in which `sq_1hz` reads high after having been low. At no other time is it high.
- R7: When `rst` and `ref_en` are high at the same edge, reset wins and the count stays at zero.
- R8: After 2^(C+2) enables, all stages return to zero together in the same cycle. The chain then repeats from the start.
- R9: The enables do not need to be evenly spaced. Outputs depend only on the number of enables since reset, never on the gaps between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the reference |
| rst | input | 1 | Synchronous reset, active high |
| ref_en | input | 1 | One-cycle pulse per reference period (32768 Hz) |
| taps | output | 10 | Tap outputs; bit 0 is the highest frequency (2048 Hz), bit 9 the lowest (2 Hz) |
| sq_1hz | output | 1 | 1 Hz square wave, 50 % duty |
| gate_half_hz | output | 1 | 0.5 Hz gate, high for one second |
| tick_1hz | output | 1 | One-cycle pulse on each rising edge of `sq_1hz` |

## Verification
Two events can fall in the same cycle. The first is the enable that completes the full two-second cycle: in that one edge the gate, the 1 Hz wave and all ten taps fall together. The second is a reset that arrives together with an enable. The bench provokes the first by running 2^(C+2) enables from reset. It compares every output after every edge with a count-based model and confirms that all of them read zero in that single wrap cycle. It provokes the second by holding `ref_en` high through a reset edge, and then checks that the first following enable leaves only the lowest stage at one.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  localparam int NUM_TAPS = 10;

  // Distance of tap j below the last core stage; 3 is skipped (16 Hz stage).
  function automatic int tap_drop(input int j);
    return (j <= 6) ? (10 - j) : (9 - j);
  endfunction

  // Stage number (1-based) that feeds tap j for a core of 'core' stages.
  function automatic int tap_stage(input int core, input int j);
    return core - tap_drop(j);
  endfunction
endpackage

// File: rtl/tbd_bin_chain.sv
module tbd_bin_chain #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH:0] carry;
  assign carry[0] = en;

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    logic stage_q;
    always_ff @(posedge clk) begin
      if (rst)           stage_q <= 1'b0;
      else if (carry[k]) stage_q <= ~stage_q;
    end
    assign q[k]       = stage_q;
    assign carry[k+1] = carry[k] & stage_q;
  end

  // R2
  hold_without_en_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !rst) |=> $stable(q));

  // R9
  first_stage_toggles_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !rst) |=> (q[0] != $past(q[0])));
endmodule

// File: rtl/tbd_tap_select.sv
module tbd_tap_select #(
  parameter int CORE  = 14,
  parameter int WIDTH = CORE + 2
) (
  input  logic [WIDTH-1:0]             q,
  output logic [tbd_pkg::NUM_TAPS-1:0] taps
);
  for (genvar j = 0; j < tbd_pkg::NUM_TAPS; j++) begin : g_tap
    localparam int BIT = tbd_pkg::tap_stage(CORE, j) - 1;
    assign taps[j] = q[BIT];
  end
endmodule

// File: rtl/tbd_tick_gen.sv
module tbd_tick_gen #(
  parameter int CORE = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CORE:0] q_low,
  output logic          tick
);
  logic rise_next;
  assign rise_next = en && (&q_low[CORE-1:0]) && !q_low[CORE];

  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= rise_next;
  end

  // R6
  tick_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    tick |-> (q_low[CORE] && !$past(q_low[CORE])));

  // R6
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/xtal_sec_timebase.sv
module xtal_sec_timebase #(
  parameter int CORE_STAGES = 14
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ref_en,
  output logic [tbd_pkg::NUM_TAPS-1:0] taps,
  output logic                         sq_1hz,
  output logic                         gate_half_hz,
  output logic                         tick_1hz
);
  localparam int WIDTH = CORE_STAGES + 2;

  logic [WIDTH-1:0] cnt;

  tbd_bin_chain #(.WIDTH(WIDTH)) u_chain (
    .clk (clk),
    .rst (rst),
    .en  (ref_en),
    .q   (cnt)
  );

  tbd_tap_select #(.CORE(CORE_STAGES), .WIDTH(WIDTH)) u_taps (
    .q    (cnt),
    .taps (taps)
  );

  tbd_tick_gen #(.CORE(CORE_STAGES)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .en    (ref_en),
    .q_low (cnt[CORE_STAGES:0]),
    .tick  (tick_1hz)
  );

  assign sq_1hz       = cnt[CORE_STAGES];
  assign gate_half_hz = cnt[CORE_STAGES+1];

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (taps == '0 && !sq_1hz && !gate_half_hz && !tick_1hz));

  // R5
  gate_on_sq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(gate_half_hz) || $fell(gate_half_hz)) |-> $fell(sq_1hz));

  // R2
  taps_need_en_chk: assert property (@(posedge clk) disable iff (rst)
    (!ref_en && !rst) |=> ($stable(taps) && !tick_1hz));
endmodule

// File: tb/xtal_sec_timebase_tb.sv
module xtal_sec_timebase_tb;
  localparam int C = 11;
  localparam int FULL = 1 << (C + 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_en = 1'b0;
  logic [9:0] taps;
  logic sq_1hz, gate_half_hz, tick_1hz;

  int checks = 0;
  int errors = 0;
  int n = 0;
  logic prev_sq = 1'b0;
  logic exp_tick = 1'b0;

  always #5 clk = ~clk;

  xtal_sec_timebase #(.CORE_STAGES(C)) u_dut (
    .clk(clk), .rst(rst), .ref_en(ref_en), .taps(taps),
    .sq_1hz(sq_1hz), .gate_half_hz(gate_half_hz), .tick_1hz(tick_1hz)
  );

  function automatic logic [9:0] model_taps(input int cnt);
    int drop [10] = '{10, 9, 8, 7, 6, 5, 4, 2, 1, 0};
    logic [9:0] r;
    for (int j = 0; j < 10; j++) r[j] = (cnt >> (C - drop[j] - 1)) & 1;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at n=%0d", req, act, exp, n);
    end
  endtask

  // One clock edge with given rst/en, model update, full compare.
  task automatic step(input logic r, input logic e);
    logic new_sq;
    @(negedge clk);
    rst = r; ref_en = e;
    @(posedge clk);
    #1;
    if (r) n = 0;
    else if (e) n = (n + 1) % FULL;
    new_sq = (n >> C) & 1;
    exp_tick = !r && !prev_sq && new_sq;
    prev_sq = new_sq;
    chk(taps == model_taps(n), "R3 taps", taps, model_taps(n));
    chk(sq_1hz == new_sq, "R4 sq_1hz", sq_1hz, new_sq);
    chk(gate_half_hz == ((n >> (C + 1)) & 1), "R5 gate", gate_half_hz, (n >> (C + 1)) & 1);
    chk(tick_1hz == exp_tick, "R6 tick", tick_1hz, exp_tick);
  endtask

  task automatic t_reset;  // R1
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    chk(taps == 0 && !sq_1hz && !gate_half_hz && !tick_1hz, "R1 reset state",
        {taps, sq_1hz, gate_half_hz, tick_1hz}, 0);
  endtask

  task automatic t_full_cycle;  // R4 R5 R6 R8
    int hi_sq = 0, hi_gate = 0, ticks = 0;
    for (int i = 0; i < FULL; i++) begin
      step(1'b0, 1'b1);
      hi_sq += sq_1hz; hi_gate += gate_half_hz; ticks += tick_1hz;
      if (i == FULL - 1)
        chk(taps == 0 && !sq_1hz && !gate_half_hz, "R8 wrap all zero",
            {taps, sq_1hz, gate_half_hz}, 0);
    end
    chk(hi_sq == FULL / 2, "R4 duty", hi_sq, FULL / 2);
    chk(hi_gate == FULL / 2, "R5 gate high length", hi_gate, FULL / 2);
    chk(ticks == 2, "R6 tick count", ticks, 2);
  endtask

  task automatic t_hold;  // R2
    logic [12:0] snap;
    for (int i = 0; i < 777; i++) step(1'b0, 1'b1);
    snap = {taps, sq_1hz, gate_half_hz, tick_1hz};
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 1'b0);
      chk({taps, sq_1hz, gate_half_hz, tick_1hz} == {snap[12:1], 1'b0}, "R2 hold",
          {taps, sq_1hz, gate_half_hz, tick_1hz}, {snap[12:1], 1'b0});
    end
  endtask

  task automatic t_sparse;  // R9
    for (int i = 0; i < 9000; i++) step(1'b0, (i % 3) == 0 || (i % 7) == 5);
    chk(n > 0, "R9 sparse progressed", n, 1);
  endtask

  task automatic t_reset_with_en;  // R7
    for (int i = 0; i < 100; i++) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    chk(taps == 0 && !sq_1hz && !gate_half_hz, "R7 reset wins",
        {taps, sq_1hz, gate_half_hz}, 0);
    step(1'b0, 1'b1);
    chk(n == 1, "R7 count restarts", n, 1);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_full_cycle();
    t_hold();
    t_reset_with_en();
    t_reset();
    t_sparse();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule